// File: doc/BRIEF.md
# Masked Syncword Hunter with Fixed-Length Payload Capture

The block watches a serial stream of recovered symbols, one bit per strobe. In its hunting state it keeps a 32-symbol sliding history. It compares that history with a programmable pattern, and only the bits enabled by a programmable care mask take part in the comparison. When the enabled bits agree, the block raises a one-cycle detection pulse.

What follows a detection depends on the operating mode. In detect-only mode the block resumes hunting at once. In receive mode it collects the next fixed number of payload bytes, emitting each byte as it completes. It flags the final byte as the end of the packet and then resumes hunting. No integrity check, descrambling or length field is handled here: the payload length is a static input.

Top module: `sync_hunt_capture`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a capture, returns the block to hunting with an all-zero history and all outputs low.
- R2: Each accepted symbol (`sym_valid` high while hunting) enters the history at bit 0, and older symbols move one place toward bit 31. A pattern and mask of 1 on bit 0 therefore detect on every symbol of value 1.
- R3: A detection occurs on the symbol after which `(history XOR sync_pattern) AND sync_mask` is zero. The symbol is included in the history, and the comparison is made while hunting.
- R4: An all-zero `sync_mask` never produces a detection, whatever the stream.
- R5: Every detection gives exactly one cycle of `det_pulse` in the cycle after the detecting symbol, and it clears the history to zero.
- R6: With `rx_mode` low at the detection, the block stays in the hunting state, so the very next pattern can detect again.
- R7: With `rx_mode` high and `pkt_len` nonzero at the detection, the next `pkt_len` × 8 symbols are packed into bytes with the first symbol as bit 7. Each eighth symbol gives a one-cycle `byte_valid` with the byte on `byte_data`.
- R8: `pkt_end` is high for one cycle together with the `byte_valid` of the last payload byte. The block then hunts again from a cleared history.
- R9: While payload is being captured, no detection occurs, even if the payload contains the pattern.
- R10: A detection with `rx_mode` high and `pkt_len` equal to zero behaves as in detect-only mode.
- R11: Cycles with `sym_valid` low change no state and leave `det_pulse`, `byte_valid` and `pkt_end` low in the following cycle.
- R12: Mode and length are sampled at the detection. Changing `rx_mode` or `pkt_len` during a capture does not alter the packet being captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Strobe: `sym_bit` carries a new symbol |
| sym_bit | input | 1 | Recovered symbol value |
| sync_pattern | input | 32 | Pattern to hunt for |
| sync_mask | input | 32 | Care mask, 1 = bit is compared |
| rx_mode | input | 1 | 0 = detect only, 1 = capture payload |
| pkt_len | input | 8 | Payload length in bytes |
| det_pulse | output | 1 | One-cycle detection pulse |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Assembled payload byte, first symbol in bit 7 |
| pkt_end | output | 1 | Marks the last payload byte |

## Verification
The assertions assume that `sym_valid` is low while reset is applied. They also assume that pattern and mask change only while no symbol is being accepted. The assertion that ties a detection to a nonzero mask relies on this, because it looks at the mask one cycle back. The bench follows these assumptions: it reconfigures only between scenarios, with the strobe low. The one exception is that it deliberately changes mode and length during a capture, and those inputs are sampled only at detection. Strobe gaps of zero and one idle cycle are both used, so that back-to-back and sparse symbol streams are both covered.

// File: rtl/sh_pkg.sv
package sh_pkg;

    localparam int SYNC_BITS = 32;
    localparam int BYTE_BITS = 8;
    localparam int BITCNT_W  = $clog2(BYTE_BITS);

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_CAPT = 1'b1
    } hunt_state_e;

    typedef struct packed {
        logic                 vld;
        logic                 last;
        logic [BYTE_BITS-1:0] data;
    } byte_beat_t;

endpackage

// File: rtl/sh_history.sv
module sh_history
    import sh_pkg::*;
#(
    parameter int W = SYNC_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         clear,
    input  logic         bit_in,
    input  logic [W-1:0] pattern,
    input  logic [W-1:0] mask,
    output logic         hit
);

    logic [W-1:0] hist_q;
    logic [W-1:0] hist_nxt;
    logic [W-1:0] diff;

    // newest symbol lands in bit 0
    assign hist_nxt = {hist_q[W-2:0], bit_in};
    assign diff     = (hist_nxt ^ pattern) & mask;
    assign hit      = (|mask) && !(|diff);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= hist_nxt;
        end
    end

    // R2: accepted symbol appears in the lowest history bit
    a_r2_lsb_newest: assert property (@(posedge clk) disable iff (rst)
        (shift && !clear) |=> (hist_q[0] == $past(bit_in)));

endmodule

// File: rtl/sh_deframer.sv
module sh_deframer
    import sh_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             shift,
    input  logic             bit_in,
    input  logic [LEN_W-1:0] len,
    output byte_beat_t       beat,
    output logic             finish
);

    logic [BITCNT_W-1:0]  bitcnt;
    logic [BYTE_BITS-2:0] sreg;
    logic [LEN_W-1:0]     bytecnt;
    logic [LEN_W-1:0]     len_q;
    logic                 byte_done;
    logic [LEN_W:0]       bytecnt_inc;

    assign byte_done   = shift && (bitcnt == BITCNT_W'(BYTE_BITS - 1));
    assign bytecnt_inc = {1'b0, bytecnt} + 1'b1;
    assign finish      = byte_done && (bytecnt_inc == {1'b0, len_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt  <= '0;
            sreg    <= '0;
            bytecnt <= '0;
            len_q   <= '0;
            beat    <= '0;
        end else begin
            beat.vld  <= byte_done;
            beat.last <= finish;
            if (byte_done) begin
                beat.data <= {sreg, bit_in};
            end
            if (start) begin
                bitcnt  <= '0;
                bytecnt <= '0;
                len_q   <= len;
            end else if (shift) begin
                sreg <= {sreg[BYTE_BITS-3:0], bit_in};
                if (byte_done) begin
                    bitcnt  <= '0;
                    bytecnt <= bytecnt_inc[LEN_W-1:0];
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R7: never more bytes than the latched length
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        shift |-> (bytecnt < len_q));

endmodule

// File: rtl/sync_hunt_capture.sv
module sync_hunt_capture
    import sh_pkg::*;
#(
    parameter int SYNC_W = SYNC_BITS,
    parameter int LEN_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_valid,
    input  logic                 sym_bit,
    input  logic [SYNC_W-1:0]    sync_pattern,
    input  logic [SYNC_W-1:0]    sync_mask,
    input  logic                 rx_mode,
    input  logic [LEN_W-1:0]     pkt_len,
    output logic                 det_pulse,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data,
    output logic                 pkt_end
);

    hunt_state_e state;
    logic        hunting;
    logic        hist_shift;
    logic        hit;
    logic        det_now;
    logic        cap_start;
    logic        cap_shift;
    logic        cap_finish;
    logic        det_q;
    byte_beat_t  beat;

    assign hunting    = (state == ST_HUNT);
    assign hist_shift = sym_valid && hunting;
    assign det_now    = hist_shift && hit;
    assign cap_start  = det_now && rx_mode && (pkt_len != '0);
    assign cap_shift  = sym_valid && (state == ST_CAPT);

    sh_history #(.W(SYNC_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .shift   (hist_shift),
        .clear   (det_now || cap_finish),
        .bit_in  (sym_bit),
        .pattern (sync_pattern),
        .mask    (sync_mask),
        .hit     (hit)
    );

    sh_deframer #(.LEN_W(LEN_W)) u_defr (
        .clk    (clk),
        .rst    (rst),
        .start  (cap_start),
        .shift  (cap_shift),
        .bit_in (sym_bit),
        .len    (pkt_len),
        .beat   (beat),
        .finish (cap_finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            det_q <= 1'b0;
        end else begin
            det_q <= det_now;
            case (state)
                ST_HUNT: if (cap_start)  state <= ST_CAPT;
                ST_CAPT: if (cap_finish) state <= ST_HUNT;
                default: state <= ST_HUNT;
            endcase
        end
    end

    assign det_pulse  = det_q;
    assign byte_valid = beat.vld;
    assign byte_data  = beat.data;
    assign pkt_end    = beat.last;

    // R9: a detection only ever comes out of the hunting state
    a_r9_no_det_in_capture: assert property (@(posedge clk) disable iff (rst)
        det_pulse |-> ($past(state) == ST_HUNT));

    // R8: end of packet rides on the final byte strobe
    a_r8_end_with_byte: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> byte_valid);

    // R8: after the last byte the block is hunting again
    a_r8_back_to_hunt: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> (state == ST_HUNT));

    // R11: no symbol, no output event
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(sym_valid) |-> !(det_pulse || byte_valid || pkt_end));

    // R4: zero mask cannot have produced a detection
    a_r4_zero_mask: assert property (@(posedge clk) disable iff (rst)
        det_pulse |-> ($past(sync_mask) != '0));

endmodule

// File: tb/sync_hunt_capture_tb.sv
`timescale 1ns/1ps
module sync_hunt_capture_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sym_valid = 1'b0;
    logic        sym_bit = 1'b0;
    logic [31:0] pat = 32'hC5A3_96E1;
    logic [31:0] msk = 32'hFFFF_FFFF;
    logic        rx_mode = 1'b0;
    logic [7:0]  plen = 8'd0;
    logic        det_pulse, byte_valid, pkt_end;
    logic [7:0]  byte_data;

    sync_hunt_capture u_dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bit(sym_bit),
        .sync_pattern(pat), .sync_mask(msk), .rx_mode(rx_mode), .pkt_len(plen),
        .det_pulse(det_pulse), .byte_valid(byte_valid), .byte_data(byte_data),
        .pkt_end(pkt_end)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R3";
    int    det_seen = 0, bytes_seen = 0, ends_seen = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference
    logic [31:0] m_hist = '0;
    bit          m_cap = 0;
    int          m_bits = 0, m_bytes = 0, m_len = 0;
    logic [7:0]  m_sh = '0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic model_reset();
        m_hist = '0; m_cap = 0; m_bits = 0; m_bytes = 0; m_len = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sym_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", "det after reset", det_pulse, 0);
        check("R1", "byte_valid after reset", byte_valid, 0);
        check("R1", "end after reset", pkt_end, 0);
    endtask

    task automatic send(input logic b, input int gap);
        logic [31:0] nh;
        logic e_det = 0, e_bv = 0, e_end = 0;
        logic [7:0] e_byte = '0;
        if (!m_cap) begin
            nh = {m_hist[30:0], b};
            if (msk != 0 && ((nh ^ pat) & msk) == 0) begin
                e_det = 1; m_hist = '0;
                if (rx_mode && plen != 0) begin
                    m_cap = 1; m_bits = 0; m_bytes = 0; m_len = plen;
                end
            end else begin
                m_hist = nh;
            end
        end else begin
            m_sh = {m_sh[6:0], b};
            m_bits++;
            if (m_bits == 8) begin
                e_bv = 1; e_byte = m_sh; m_bits = 0; m_bytes++;
                if (m_bytes == m_len) begin
                    e_end = 1; m_cap = 0; m_hist = '0;
                end
            end
        end
        sym_valid = 1'b1; sym_bit = b;
        @(negedge clk);
        check(cur_req, "det_pulse", det_pulse, e_det);
        check(cur_req, "byte_valid", byte_valid, e_bv);
        if (e_bv) check(cur_req, "byte_data", byte_data, e_byte);
        check(cur_req, "pkt_end", pkt_end, e_end);
        if (det_pulse) det_seen++;
        if (byte_valid) bytes_seen++;
        if (pkt_end) ends_seen++;
        if (gap > 0) begin
            sym_valid = 1'b0;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R11", "quiet outputs", {det_pulse, byte_valid, pkt_end}, 0);
            end
        end
    endtask

    task automatic idle();
        sym_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w, input int gap);
        for (int i = 31; i >= 0; i--) send(w[i], gap);
    endtask

    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 7; i >= 0; i--) send(v[i], gap);
    endtask

    task automatic send_noise(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0], gap);
        end
    endtask

    task automatic clear_counts();
        det_seen = 0; bytes_seen = 0; ends_seen = 0;
    endtask

    initial begin
        do_reset();

        // R3 / R5: full mask, pattern embedded in noise twice
        cur_req = "R3"; rx_mode = 0; msk = '1; clear_counts();
        send_noise(50, 0); send_word(pat, 0); send_noise(40, 0);
        send_word(pat, 1); send_noise(20, 0); idle();
        check("R5", "detections full mask", det_seen, 2);

        // R6: detect-only re-arms immediately
        cur_req = "R6"; clear_counts();
        send_word(pat, 0); send_word(pat, 0); idle();
        check("R6", "back-to-back detections", det_seen, 2);

        // R2: newest symbol at bit 0, oldest at bit 31
        cur_req = "R2"; pat = 32'h0000_0001; msk = 32'h0000_0001; clear_counts();
        send_noise(40, 0); idle();
        pat = 32'h8000_0000; msk = 32'h8000_0000;
        send_noise(120, 0); send_word(32'h8000_0000, 0); idle();

        // R3: partial mask gives frequent hits
        cur_req = "R3"; pat = 32'h1234_5A5A; msk = 32'h0000_00FF;
        send_noise(300, 0); idle();

        // R4: zero mask never detects
        cur_req = "R4"; pat = 32'hC5A3_96E1; msk = '0; clear_counts();
        send_word(pat, 0); send_noise(60, 0); send_word(32'h0, 0); idle();
        check("R4", "zero-mask detections", det_seen, 0);

        // R7 / R8 sweep over length and strobe gap
        msk = '1; rx_mode = 1;
        for (int gap = 0; gap < 2; gap++) begin
            for (int len = 1; len <= 4; len++) begin
                cur_req = "R7"; plen = 8'(len); clear_counts();
                send_noise(30, gap); send_word(pat, gap);
                for (int k = 0; k < len; k++) send_byte(8'(8'h96 + k * 37), gap);
                cur_req = "R8";
                send_noise(20, gap); idle();
                check("R7", "payload bytes", bytes_seen, len);
                check("R8", "end markers", ends_seen, 1);
            end
        end

        // R9: pattern inside payload is ignored, detection resumes after
        cur_req = "R9"; plen = 8; clear_counts();
        send_word(pat, 0); send_word(pat, 0); send_word(pat, 0);
        check("R9", "detections during capture", det_seen, 1);
        send_word(pat, 0); idle();
        check("R9", "detection after packet", det_seen, 2);
        send_noise(64, 0); idle();
        rx_mode = 0;

        // R10: receive mode with zero length behaves as detect-only
        cur_req = "R10"; rx_mode = 1; plen = 0; clear_counts();
        send_word(pat, 0); send_byte(8'h55, 0); send_word(pat, 0); idle();
        check("R10", "zero-length bytes", bytes_seen, 0);
        check("R10", "zero-length detections", det_seen, 2);

        // R12: mode and length changes during capture are ignored
        cur_req = "R12"; rx_mode = 1; plen = 2; clear_counts();
        send_word(pat, 0); idle();
        rx_mode = 0; plen = 5;
        send_byte(8'hA7, 0); send_byte(8'h3C, 0); send_noise(24, 0); idle();
        check("R12", "bytes with late config change", bytes_seen, 2);
        check("R12", "end markers", ends_seen, 1);

        // R1: reset in the middle of a capture
        rx_mode = 1; plen = 4; clear_counts();
        cur_req = "R1";
        send_word(pat, 0); send_byte(8'h11, 0);
        do_reset();
        clear_counts();
        send_byte(8'h22, 0); send_byte(8'h33, 0); send_byte(8'h44, 0); idle();
        check("R1", "bytes after reset", bytes_seen, 0);
        send_word(pat, 0); send_byte(8'hF0, 0);
        send_byte(8'h0F, 0); send_byte(8'h5A, 0); send_byte(8'hA5, 0); idle();
        check("R1", "capture after reset", bytes_seen, 4);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule